// File: doc/BRIEF.md
# Flash Bank Command Sequencer

This block turns high-level requests into the write cycles needed by a 32-bit flash bank made of narrower devices that share one data bus. Each command code is copied into every device lane, so all chips on the bus receive the same command in the same bus cycle. A request brings a mode bit, a word address and a data word. Mode 0 treats the bank as two 16-bit devices and runs a block erase. Mode 1 treats the bank as four 8-bit devices and runs an unlock-and-program sequence that ends by writing the data word.

Each bus write keeps chip-enable and write-enable low for a fixed number of cycles, then high for a recovery gap. After the last write the sequencer watches per-lane ready and failure inputs, and only the lanes used by the current mode count. When the operation completes it pulses `done` for one cycle, and it raises `err` in that same cycle if any active lane failed. The block takes a request only while it is idle.

Top module: `flash_bank_seq`

## Requirements
- R1: While reset is held, and in the cycles after release with no request, `busy`, `done` and `err` are 0 and `bus_ce_n` and `bus_we_n` are 1.
- R2: A request is accepted only in a cycle where `busy` is 0 and `req_valid` is 1. `busy` is 1 from the next cycle until the operation ends. While `busy` is 1, `req_valid` is ignored: it causes no extra writes and no extra completion.
- R3: A mode 0 request (two 16-bit lanes: lane 0 on bits 15:0, lane 1 on bits 31:16) produces exactly three writes, all to the request address, in this order: 0x00500050, 0x00200020, 0x00D000D0.
- R4: A mode 1 request (four 8-bit lanes, lane i on bits 8i+7:8i) produces exactly four writes in this order: 0xAAAAAAAA to word 0x555, 0x55555555 to word 0x2AA, 0xA0A0A0A0 to word 0x555, then the request data, unchanged, to the request address.
- R5: In every write, `bus_ce_n` and `bus_we_n` fall together and stay low for exactly PULSE_CYC cycles, with `bus_addr` and `bus_wdata` stable. Within one request, the next write starts after exactly GAP_CYC cycles with both strobes high.
- R6: The address and data are captured when the request is accepted. Changes on `req_addr`, `req_data` and `req_mode` while `busy` is 1 do not change the writes.
- R7: After the last recovery gap, `done` rises only once every active lane has `lane_ready` at 1. Lanes 0 and 1 are active in mode 0 and lanes 0 to 3 in mode 1. The ready state of inactive lanes is ignored. In the cycle `done` is 1, `busy` is 0.
- R8: If any active lane has `lane_fail` at 1 while the sequencer waits, the operation ends with `done` and `err` both 1. This holds even when all lanes are ready in that cycle. Failure on inactive lanes is ignored.
- R9: `done` and `err` last exactly one cycle, and `err` is 1 only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_mode | input | 1 | 0: two 16-bit lanes, erase; 1: four 8-bit lanes, program |
| req_addr | input | ADDR_W | Word address of the block or target word |
| req_data | input | BUS_W | Word to program (mode 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| bus_addr | output | ADDR_W | Flash word address |
| bus_wdata | output | BUS_W | Flash write data, command codes replicated per lane |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| lane_ready | input | BUS_W/8 | Per-lane ready indication |
| lane_fail | input | BUS_W/8 | Per-lane failure indication |

## Verification
Two events can fall in the same cycle. The first is the completion pulse together with a new request. The bench raises `req_valid` in the very cycle it sees `done`, then expects `busy` in the next cycle and the full write sequence of the new request after it. The second is a ready and a failure report in the same polling cycle. The bench holds all lanes ready while one active lane reports failure, and expects `done` with `err` set. A scoreboard checks each lane's decoded slice of every write, so an error in replication or ordering shows up on the lane where it happens.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STROBE  = 2'd1,
    ST_RECOVER = 2'd2,
    ST_POLL    = 2'd3
  } seq_state_e;

  typedef enum logic {
    SET_X16_ERASE  = 1'b0,
    SET_X8_PROGRAM = 1'b1
  } cmd_set_e;

  localparam int STEP_W = 2;

  // last step index of each sequence
  localparam logic [STEP_W-1:0] ERASE_LAST_STEP = 2'd2;
  localparam logic [STEP_W-1:0] PROG_LAST_STEP  = 2'd3;

  // 16-bit lane command codes
  localparam logic [15:0] X16_STATUS_CLEAR  = 16'h0050;
  localparam logic [15:0] X16_ERASE_ARM     = 16'h0020;
  localparam logic [15:0] X16_ERASE_COMMIT  = 16'h00D0;

  // 8-bit lane command codes
  localparam logic [7:0]  X8_KEY_FIRST      = 8'hAA;
  localparam logic [7:0]  X8_KEY_SECOND     = 8'h55;
  localparam logic [7:0]  X8_WRITE_ARM      = 8'hA0;

  // unlock word offsets
  localparam int KEY_OFS_FIRST  = 'h555;
  localparam int KEY_OFS_SECOND = 'h2AA;

endpackage

// File: rtl/lane_replicate.sv
module lane_replicate #(
  parameter int BUS_W  = 32,
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] lane_val,
  output logic [BUS_W-1:0]  bus_val
);
  localparam int COPIES = BUS_W / LANE_W;

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    assign bus_val[g*LANE_W +: LANE_W] = lane_val;
  end
endmodule

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 22
) (
  input  cmd_set_e            cmd_set,
  input  logic [STEP_W-1:0]   step,
  input  logic [ADDR_W-1:0]   tgt_addr,
  input  logic [BUS_W-1:0]    tgt_data,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [BUS_W-1:0]    cmd_data,
  output logic                last_step
);
  logic [15:0]      half_code;
  logic [7:0]       byte_code;
  logic [BUS_W-1:0] half_bus;
  logic [BUS_W-1:0] byte_bus;

  always_comb begin
    case (step)
      2'd0:    half_code = X16_STATUS_CLEAR;
      2'd1:    half_code = X16_ERASE_ARM;
      default: half_code = X16_ERASE_COMMIT;
    endcase
  end

  always_comb begin
    case (step)
      2'd0:    byte_code = X8_KEY_FIRST;
      2'd1:    byte_code = X8_KEY_SECOND;
      default: byte_code = X8_WRITE_ARM;
    endcase
  end

  lane_replicate #(.BUS_W(BUS_W), .LANE_W(16)) u_rep_half (
    .lane_val (half_code),
    .bus_val  (half_bus)
  );

  lane_replicate #(.BUS_W(BUS_W), .LANE_W(8)) u_rep_byte (
    .lane_val (byte_code),
    .bus_val  (byte_bus)
  );

  always_comb begin
    if (cmd_set == SET_X16_ERASE) begin
      cmd_addr  = tgt_addr;
      cmd_data  = half_bus;
      last_step = (step == ERASE_LAST_STEP);
    end else begin
      case (step)
        2'd0:    cmd_addr = ADDR_W'(KEY_OFS_FIRST);
        2'd1:    cmd_addr = ADDR_W'(KEY_OFS_SECOND);
        2'd2:    cmd_addr = ADDR_W'(KEY_OFS_FIRST);
        default: cmd_addr = tgt_addr;
      endcase
      cmd_data  = (step == PROG_LAST_STEP) ? tgt_data : byte_bus;
      last_step = (step == PROG_LAST_STEP);
    end
  end
endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
  parameter int PULSE_CYC = 3,
  parameter int GAP_CYC   = 2,
  localparam int MAX_CYC  = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic in_gap,
  output logic phase_end
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;

  assign limit     = in_gap ? CNT_W'(GAP_CYC - 1) : CNT_W'(PULSE_CYC - 1);
  assign phase_end = en && (cnt_q == limit);

  always_comb begin
    if (!en || phase_end) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/flash_lane_status.sv
module flash_lane_status
  import flash_seq_pkg::*;
#(
  parameter int  BUS_W     = 32,
  localparam int LANES     = BUS_W / 8,
  localparam int X16_LANES = BUS_W / 16
) (
  input  cmd_set_e         cmd_set,
  input  logic [LANES-1:0] lane_ready,
  input  logic [LANES-1:0] lane_fail,
  output logic             all_ready,
  output logic             any_fail
);
  logic [LANES-1:0] active;
  logic [LANES-1:0] ok_vec;
  logic [LANES-1:0] bad_vec;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < X16_LANES) begin : g_always
      assign active[g] = 1'b1;
    end else begin : g_wide_only
      assign active[g] = (cmd_set == SET_X8_PROGRAM);
    end
    assign ok_vec[g]  = lane_ready[g] | ~active[g];
    assign bad_vec[g] = lane_fail[g] & active[g];
  end

  assign all_ready = &ok_vec;
  assign any_fail  = |bad_vec;
endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
  import flash_seq_pkg::*;
#(
  parameter int  BUS_W     = 32,
  parameter int  ADDR_W    = 22,
  parameter int  PULSE_CYC = 3,
  parameter int  GAP_CYC   = 2,
  localparam int LANES     = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_wdata,
  output logic              bus_ce_n,
  output logic              bus_we_n,
  input  logic [LANES-1:0]  lane_ready,
  input  logic [LANES-1:0]  lane_fail
);
  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  cmd_set_e          set_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              accept;

  logic              phase_end;
  logic              timer_en;
  logic              in_gap;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BUS_W-1:0]  cmd_data;
  logic              last_step;
  logic              all_ready;
  logic              any_fail;

  assign timer_en = (state_q == ST_STROBE) || (state_q == ST_RECOVER);
  assign in_gap   = (state_q == ST_RECOVER);

  flash_pulse_timer #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (timer_en),
    .in_gap    (in_gap),
    .phase_end (phase_end)
  );

  flash_cmd_table #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_table (
    .cmd_set   (set_q),
    .step      (step_q),
    .tgt_addr  (addr_q),
    .tgt_data  (data_q),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .last_step (last_step)
  );

  flash_lane_status #(.BUS_W(BUS_W)) u_status (
    .cmd_set    (set_q),
    .lane_ready (lane_ready),
    .lane_fail  (lane_fail),
    .all_ready  (all_ready),
    .any_fail   (any_fail)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_STROBE;
          step_d  = '0;
        end
      end
      ST_STROBE: begin
        if (phase_end) state_d = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (phase_end) begin
          if (last_step) begin
            state_d = ST_POLL;
          end else begin
            state_d = ST_STROBE;
            step_d  = step_q + 1'b1;
          end
        end
      end
      ST_POLL: begin
        if (any_fail) begin
          done_d  = 1'b1;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (all_ready) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= SET_X16_ERASE;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      set_q  <= cmd_set_e'(req_mode);
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign bus_ce_n  = (state_q != ST_STROBE);
  assign bus_we_n  = (state_q != ST_STROBE);
  assign bus_addr  = timer_en ? cmd_addr : '0;
  assign bus_wdata = timer_en ? cmd_data : '0;
endmodule

// File: rtl/flash_bank_seq_chk.sv
module flash_bank_seq_chk #(
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 22,
  parameter int PULSE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_ce_n,
  input logic              bus_we_n
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        low_run <= '0;
    else if (!bus_we_n && low_run != 16'hFFFF) low_run <= low_run + 1'b1;
    else if (bus_we_n)                 low_run <= '0;
  end

  p_strobes_paired_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce_n == bus_we_n);

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_we_n);

  p_accept_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  p_done_releases_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_ends_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_stable_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n && !$past(bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> (low_run == 16'(PULSE_CYC)));
endmodule

bind flash_bank_seq flash_bank_seq_chk #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ce_n  (bus_ce_n),
  .bus_we_n  (bus_we_n)
);

// File: tb/flash_bank_seq_tb_top.sv
module flash_bank_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 22;
  localparam int PULSE      = 3;
  localparam int GAP        = 2;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic          mode;
    logic          first;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_mode = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_data = '0;
  logic [3:0]    lane_ready = 4'hF;
  logic [3:0]    lane_fail = 4'h0;
  logic          busy, done, err, bus_ce_n, bus_we_n;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;

  int   checks = 0;
  int   fails = 0;
  int   done_cnt = 0;
  int   cyc_cnt = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bank_seq #(.BUS_W(32), .ADDR_W(AW), .PULSE_CYC(PULSE), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done), .err(err),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .lane_ready(lane_ready), .lane_fail(lane_fail)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=<%0d cycles", cyc_cnt, 50000);
      summary();
      $finish;
    end
  end

  // driver: push expected writes, present request for one cycle
  task automatic issue(input logic m, input logic [AW-1:0] a, input logic [31:0] d);
    req_mode  = m;
    req_addr  = a;
    req_data  = d;
    req_valid = 1'b1;
    if (!m) begin
      exp_q.push_back('{addr: a, data: 32'h00500050, mode: 1'b0, first: 1'b1});
      exp_q.push_back('{addr: a, data: 32'h00200020, mode: 1'b0, first: 1'b0});
      exp_q.push_back('{addr: a, data: 32'h00D000D0, mode: 1'b0, first: 1'b0});
    end else begin
      exp_q.push_back('{addr: AW'('h555), data: {4{8'hAA}}, mode: 1'b1, first: 1'b1});
      exp_q.push_back('{addr: AW'('h2AA), data: {4{8'h55}}, mode: 1'b1, first: 1'b0});
      exp_q.push_back('{addr: AW'('h555), data: {4{8'hA0}}, mode: 1'b1, first: 1'b0});
      exp_q.push_back('{addr: a,          data: d,          mode: 1'b1, first: 1'b0});
    end
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_data  = ~d;
    req_mode  = ~m;
    check(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
  endtask

  task automatic wait_done(input string tag);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) return;
    end
    check(1'b0, tag, 64'd0, 64'd1);
  endtask

  // monitor: per-lane decode and compare against the scoreboard
  logic          prev_we = 1'b1;
  int            low_run = 0;
  int            high_run = 0;
  logic [AW-1:0] cur_addr;
  logic [31:0]   cur_data;
  bit            stable_ok;
  always @(negedge clk) begin
    exp_t it;
    bit   lane_ok;
    if (!rst_n) begin
      prev_we = 1'b1;
    end else begin
      if (done) done_cnt++;
      check(bus_ce_n == bus_we_n, "R5 strobes paired", 64'(bus_ce_n), 64'(bus_we_n));
      if (!bus_we_n) begin
        if (prev_we) begin
          cur_addr  = bus_addr;
          cur_data  = bus_wdata;
          stable_ok = 1'b1;
          low_run   = 1;
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected write", 64'(bus_wdata), 64'd0);
          end else begin
            it = exp_q.pop_front();
            lane_ok = 1'b1;
            if (!it.mode) begin
              for (int l = 0; l < 2; l++)
                if (bus_wdata[l*16 +: 16] != it.data[l*16 +: 16]) begin
                  lane_ok = 1'b0;
                  $display("FAIL R3 lane %0d actual=%0h expected=%0h", l,
                           bus_wdata[l*16 +: 16], it.data[l*16 +: 16]);
                end
              check(lane_ok, "R3 erase write data", 64'(bus_wdata), 64'(it.data));
              check(bus_addr == it.addr, "R3 erase write addr", 64'(bus_addr), 64'(it.addr));
            end else begin
              for (int l = 0; l < 4; l++)
                if (bus_wdata[l*8 +: 8] != it.data[l*8 +: 8]) begin
                  lane_ok = 1'b0;
                  $display("FAIL R4 lane %0d actual=%0h expected=%0h", l,
                           bus_wdata[l*8 +: 8], it.data[l*8 +: 8]);
                end
              check(lane_ok, "R4 R6 program write data", 64'(bus_wdata), 64'(it.data));
              check(bus_addr == it.addr, "R4 R6 program write addr", 64'(bus_addr), 64'(it.addr));
            end
            if (!it.first)
              check(high_run == GAP, "R5 recovery gap", 64'(high_run), 64'(GAP));
          end
        end else begin
          low_run++;
          if (bus_addr != cur_addr || bus_wdata != cur_data) stable_ok = 1'b0;
        end
      end else begin
        if (!prev_we) begin
          check(low_run == PULSE, "R5 pulse width", 64'(low_run), 64'(PULSE));
          check(stable_ok, "R5 stable during pulse", 64'(stable_ok), 64'd1);
          high_run = 1;
        end else begin
          high_run++;
        end
      end
      prev_we = bus_we_n;
    end
  end

  initial begin
    int base;
    // R1 reset state
    repeat (3) @(negedge clk);
    check({busy, done, err, bus_ce_n, bus_we_n} == 5'b00011, "R1 reset outputs",
          64'({busy, done, err, bus_ce_n, bus_we_n}), 64'h3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({busy, done, err, bus_ce_n, bus_we_n} == 5'b00011, "R1 idle after reset",
          64'({busy, done, err, bus_ce_n, bus_we_n}), 64'h3);

    // erase in 16-bit lane mode
    issue(1'b0, 22'h01_2340, 32'hDEAD_BEEF);
    wait_done("R3 erase completion");
    check(err == 1'b0, "R7 erase no error", 64'(err), 64'd0);
    check(exp_q.size() == 0, "R3 three erase writes", 64'(exp_q.size()), 64'd0);

    // program, with ignored requests and input changes while busy
    @(negedge clk);
    base = done_cnt;
    issue(1'b1, 22'h2A_5A5A, 32'h1234_5678);
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_mode = 1'b0; req_addr = 22'h3F_0000; req_data = 32'hFFFF_0000;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    wait_done("R4 program completion");
    check(err == 1'b0, "R7 program no error", 64'(err), 64'd0);
    repeat (30) @(negedge clk);
    check(done_cnt == base + 1, "R2 single completion for ignored request", 64'(done_cnt), 64'(base + 1));
    check(busy == 1'b0, "R2 idle after ignored request", 64'(busy), 64'd0);
    check(exp_q.size() == 0, "R4 four program writes", 64'(exp_q.size()), 64'd0);

    // poll gating: active lanes not ready, inactive lanes not ready later
    lane_ready = 4'b1100;
    base = done_cnt;
    issue(1'b0, 22'h00_8000, 32'h0);
    repeat (40) @(negedge clk);
    check(busy == 1'b1, "R7 waits for active lanes", 64'(busy), 64'd1);
    check(done_cnt == base, "R7 no done before ready", 64'(done_cnt), 64'(base));
    lane_ready = 4'b0011;
    wait_done("R7 inactive lanes ignored");
    check(err == 1'b0, "R7 ready completion error flag", 64'(err), 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R9 done lasts one cycle", 64'(done), 64'd0);

    // failure on a wide-mode lane
    lane_ready = 4'b0000; lane_fail = 4'b0100;
    issue(1'b1, 22'h10_0001, 32'hCAFE_F00D);
    wait_done("R8 failure completion");
    check(err == 1'b1, "R8 error on active lane", 64'(err), 64'd1);
    @(negedge clk);
    check({done, err} == 2'b00, "R9 err lasts one cycle", 64'({done, err}), 64'd0);

    // failure on inactive lane in 16-bit mode ignored
    lane_ready = 4'b0011; lane_fail = 4'b1000;
    issue(1'b0, 22'h20_0000, 32'h0);
    wait_done("R8 inactive failure completion");
    check(err == 1'b0, "R8 inactive lane failure ignored", 64'(err), 64'd0);

    // ready and failure in the same cycle: failure wins
    @(negedge clk);
    lane_ready = 4'b1111; lane_fail = 4'b0001;
    issue(1'b0, 22'h04_4444, 32'h0);
    wait_done("R8 same-cycle completion");
    check(err == 1'b1, "R8 failure beats ready", 64'(err), 64'd1);
    lane_fail = 4'b0000;

    // new request in the completion cycle
    @(negedge clk);
    issue(1'b1, 22'h15_1515, 32'h8001_7FFE);
    wait_done("R2 first of back-to-back");
    issue(1'b0, 22'h3C_0000, 32'h0);
    wait_done("R2 second of back-to-back");
    check(err == 1'b0, "R2 back-to-back no error", 64'(err), 64'd0);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 R4 all expected writes seen", 64'(exp_q.size()), 64'd0);
    check(busy == 1'b0, "R1 idle at end", 64'(busy), 64'd0);

    summary();
    $finish;
  end
endmodule